// File: doc/BRIEF.md
# IF Sampler and Quadrature Downconverter

This block accepts a one- or two-bit intermediate-frequency stream from an external radio. The stream arrives with no fixed timing relation to the logic clock. The block first passes it through a two-stage synchroniser. It then multiplies it by a local carrier reference twice: once in phase and once a quarter cycle later. The results are signed in-phase (I) and quadrature (Q) baseband samples near zero frequency. The chip has a single instance of this block, and all correlation channels read its output.

The sample rate is four times the nominal 4.092 MHz carrier, or 16.368 MHz. The reference therefore steps one quarter cycle per sample. At each step every reference value is +1, 0 or −1, so the mixer only selects a sign or forces zero and needs no multiplier. The block does not remove the residual offset of up to ±132 kHz caused by oscillator error; that offset passes through to the I and Q outputs. Every pipeline register advances only on a clock in which `smp_en` is high.

Top module: `if_downmix`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `iq_vld` is low and `i_smp` and `q_smp` are zero. Reset is synchronous and active high.
- R2: The sample presented with strobe n appears at the outputs after strobe n+2. This is three strobes of latency: two synchroniser stages and one mixing register.
- R3: The in-phase reference for strobe n, counted from 0 after reset, is +1, 0, −1, 0 for n mod 4 = 0, 1, 2, 3. `i_smp` equals this reference times the decoded sample.
- R4: The quadrature reference for strobe n is 0, +1, 0, −1 for n mod 4 = 0, 1, 2, 3. `q_smp` equals this reference times the decoded sample.
- R5: The two-bit input is decoded as sign-magnitude. Bit 1 is the sign (1 = negative). Bit 0 selects magnitude 3 when set and magnitude 1 when clear. The decoded values are 00→+1, 01→+3, 10→−1, 11→−3.
- R6: In a cycle where `smp_en` is low, `i_smp` and `q_smp` keep their values, the raw input is ignored, and the reference phase does not advance.
- R7: `iq_vld` is high for exactly the cycle after each strobe, counting from the third strobe after reset onward. It is low at all other times.
- R8: Whenever `iq_vld` is high, exactly one of `i_smp` and `q_smp` is nonzero.
- R9: A reset in the middle of a stream restarts the phase count at 0 and restarts the R7 priming count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe; advances the pipeline and the phase |
| if_raw | input | IN_W (2) | Asynchronous IF data, sign-magnitude coded |
| i_smp | output | 3 | Signed in-phase baseband sample |
| q_smp | output | 3 | Signed quadrature baseband sample |
| iq_vld | output | 1 | One-cycle pulse when a new I/Q pair is ready |

## Verification
The hardest case to reach is a gap in the strobe while samples are still inside the synchroniser. If a gap shifts either the phase or the delayed sample, every later I/Q pair is off by one. Random stimulus toggles `smp_en` with about 30% idle cycles and changes `if_raw` during the gaps. A bench model indexed by strobe count, not by cycle count, predicts every output. Directed runs check the exact latency edge with a continuous strobe and a reset in mid-stream while samples are in flight.

// File: rtl/if_downmix.sv
module if_downmix #(
  parameter int IN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic [IN_W-1:0]  if_raw,
  output logic signed [2:0] i_smp,
  output logic signed [2:0] q_smp,
  output logic             iq_vld
);

  localparam int OUT_W = 3;

  logic [IN_W-1:0] sync_a, sync_b;
  logic [1:0]      phase;
  logic [1:0]      fill;
  logic signed [OUT_W-1:0] val, i_nxt, q_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
    end else if (smp_en) begin
      sync_a <= if_raw;
      sync_b <= sync_a;
    end
  end

  generate
    if (IN_W == 1) begin : g_one_bit
      assign val = sync_b[0] ? -3'sd1 : 3'sd1;
    end else begin : g_two_bit
      logic signed [OUT_W-1:0] mag;
      assign mag = sync_b[0] ? 3'sd3 : 3'sd1;
      assign val = sync_b[IN_W-1] ? -mag : mag;
    end
  endgenerate

  assign i_nxt = phase[0] ? 3'sd0 : (phase[1] ? -val : val);
  assign q_nxt = phase[0] ? (phase[1] ? -val : val) : 3'sd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 2'd0;
      fill   <= 2'd0;
      i_smp  <= '0;
      q_smp  <= '0;
      iq_vld <= 1'b0;
    end else begin
      iq_vld <= smp_en && (fill == 2'd2);
      if (smp_en) begin
        phase <= phase + 2'd1;
        if (fill != 2'd2) fill <= fill + 2'd1;
        i_smp <= i_nxt;
        q_smp <= q_nxt;
      end
    end
  end

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !$past(rst)) |=> (phase == $past(phase) + 2'd1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(smp_en) && !$past(rst)) |-> ($stable(i_smp) && $stable(q_smp)));

  assert_vld_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    iq_vld |-> $past(smp_en));

  assert_one_rail_R8: assert property (@(posedge clk) disable iff (rst)
    iq_vld |-> ((i_smp == 3'sd0) != (q_smp == 3'sd0)));

  assert_magnitude_R5: assert property (@(posedge clk) disable iff (rst)
    (i_smp != -3'sd4) && (q_smp != -3'sd4) && (i_smp != 3'sd2) && (q_smp != 3'sd2)
    && (i_smp != -3'sd2) && (q_smp != -3'sd2));

endmodule

// File: tb/if_downmix_bench.sv
module if_downmix_bench;
  logic clk = 1'b0;
  logic rst, smp_en;
  logic [1:0] if_raw;
  logic signed [2:0] i_smp, q_smp;
  logic iq_vld;

  always #2 clk = ~clk;

  if_downmix #(.IN_W(2)) u_if_downmix (
    .clk(clk), .rst(rst), .smp_en(smp_en), .if_raw(if_raw),
    .i_smp(i_smp), .q_smp(q_smp), .iq_vld(iq_vld));

  int checks = 0, failures = 0, n = 0, cycles = 0;
  logic [1:0] h0 = 0, h1 = 0;
  logic signed [2:0] ei = 0, eq = 0;
  logic ev = 0, armed = 0, prev_en = 0;
  string tag_iq = "R3";
  bit done = 0;

  function automatic logic signed [2:0] dec(input logic [1:0] r);
    logic signed [2:0] m;
    m = r[0] ? 3'sd3 : 3'sd1;
    return r[1] ? -m : m;
  endfunction

  function automatic logic signed [2:0] ref_i(input int p);
    case (p % 4) 0: return 3'sd1; 2: return -3'sd1; default: return 3'sd0; endcase
  endfunction

  function automatic logic signed [2:0] ref_q(input int p);
    case (p % 4) 1: return 3'sd1; 3: return -3'sd1; default: return 3'sd0; endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic en, input logic [1:0] raw);
    @(negedge clk);
    if (armed) begin
      chk("R7", iq_vld, ev);
      chk(prev_en ? tag_iq : "R6", i_smp, ei);
      chk(prev_en ? (tag_iq == "R3" ? "R4" : tag_iq) : "R6", q_smp, eq);
      if (iq_vld) chk("R8", ((i_smp == 0) != (q_smp == 0)), 1);
    end
    rst = r; smp_en = en; if_raw = raw;
    prev_en = en;
    if (r) begin
      ei = 0; eq = 0; ev = 0; n = 0; h0 = 0; h1 = 0;
    end else if (en) begin
      ev = (n >= 2);
      ei = ref_i(n) * dec(h1);
      eq = ref_q(n) * dec(h1);
      h1 = h0; h0 = raw; n++;
    end else begin
      ev = 0;
    end
    armed = 1;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; smp_en = 0; if_raw = 0;
    repeat (3) step(1, 0, 0);
    @(negedge clk);
    chk("R1", iq_vld, 0); chk("R1", i_smp, 0); chk("R1", q_smp, 0);
    tag_iq = "R2";
    step(0, 1, 2'b00); step(0, 1, 2'b00); step(0, 1, 2'b00);
    step(0, 1, 2'b11); step(0, 1, 2'b00); step(0, 1, 2'b00); step(0, 1, 2'b00);
    tag_iq = "R5";
    for (int k = 0; k < 16; k++) step(0, 1, 2'(k / 4));
    tag_iq = "R6";
    step(0, 0, 2'b11); step(0, 0, 2'b01); step(0, 0, 2'b10);
    step(0, 1, 2'b01); step(0, 0, 2'b11); step(0, 1, 2'b10);
    tag_iq = "R9";
    step(0, 1, 2'b01); step(1, 1, 2'b11); step(0, 1, 2'b01);
    for (int k = 0; k < 8; k++) step(0, 1, 2'(k));
    tag_iq = "R3";
    for (int k = 0; k < 3000; k++)
      step(($urandom % 500) == 0, ($urandom % 10) < 7, 2'($urandom));
    step(0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule